// File: doc/BRIEF.md
# Audio InfoFrame Packet Builder

This block keeps the payload of an audio InfoFrame in a small register bank and turns it into a complete packet in hardware. Software writes only the five meaningful payload bytes. The block supplies the fixed header, forces the trailing reserved payload bytes to zero, and rewrites any nonzero speaker-allocation value to the eight-channel code. It also keeps a live checksum that software can read back.

A control register holds an enable bit and a repeat bit. A frame trigger from the video timing logic starts a transmission when the block is enabled and idle. The packet then leaves as fourteen bytes on consecutive cycles, with a valid strobe and a first-byte marker, ready for a downstream data-island framer. With repeat set, every frame trigger sends the packet. With repeat clear, one packet is sent and the enable bit clears itself.

The bytes in flight come from a snapshot taken at launch. Register writes made during a transmission therefore take effect only from the next frame.

Top module: `aif_pkt_builder`

## Requirements
- R1: After reset the enable and repeat bits are 0, all payload bytes read 0, out_valid is 0, and the checksum register reads 0x71.
- R2: A launch happens on the clock edge where frame_tick is high while the block is enabled and idle. From the next cycle on, out_valid is high for exactly 14 cycles. The bytes are 0x84, 0x01, 0x0A, the checksum, then payload bytes 1 to 10. out_first is high only with the first byte.
- R3: Payload bytes 6 to 10 are always sent as zero. Writes to addresses 5 to 7 are ignored, and those addresses read 0.
- R4: Payload bytes 1 to 5 are written and read at addresses 0 to 4. A nonzero value written to address 3 (payload byte 4, speaker allocation) is stored as 0x13. A zero value there is stored as zero.
- R5: Address 9 reads the checksum: 0x100 minus the 8-bit sum of the three header bytes and the ten payload bytes. It follows a write on the next cycle. All 14 streamed bytes sum to 0 modulo 256.
- R6: Address 8 is the control register, with enable in bit 5 and repeat in bit 4. It reads back in the same positions. A frame_tick while enable is 0 starts nothing.
- R7: With enable and repeat both set, every frame_tick that arrives while the block is idle launches a packet, and enable stays set.
- R8: With enable set and repeat clear, a launch clears enable from the next cycle on. If a control-register write lands on the launch edge, the written value wins.
- R9: A frame_tick that arrives while a packet is streaming is ignored. This includes the edge of the last byte.
- R10: A payload write during a transmission, or on the launch edge, leaves the bytes in flight unchanged. The new value appears in the next packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 8 | Combinational register read data |
| frame_tick | input | 1 | One-cycle frame trigger |
| out_valid | output | 1 | Packet byte valid |
| out_first | output | 1 | Marks the first header byte |
| out_data | output | 8 | Packet byte |

## Verification
Two functions can fall in the same cycle: a register write and the packet launch or stream. The bench provokes this by writing a payload byte on the very edge where frame_tick launches, and again in the middle of a stream. It also writes the control register on a one-shot launch edge, and issues frame_tick on the final-byte edge. A behavioural model snapshots the payload before applying any write of that edge. Every cycle, the model's expected bytes, strobes and readback values are compared with the ports. The comparison therefore judges both that the in-flight packet is untouched and that the new value shows up one frame later.

// File: rtl/aif_pkg.sv
package aif_pkg;
  localparam int unsigned SW_N     = 5;
  localparam int unsigned DB_N     = 10;
  localparam int unsigned HDR_N    = 3;
  localparam int unsigned PKT_N    = HDR_N + 1 + DB_N;
  localparam int unsigned IDX_W    = $clog2(PKT_N);
  localparam int unsigned CA_SLOT  = 3;
  localparam int unsigned CTRL_ADDR = 8;
  localparam int unsigned CSUM_ADDR = 9;
  localparam int unsigned EN_BIT   = 5;
  localparam int unsigned REP_BIT  = 4;

  localparam logic [7:0] HDR_TYPE = 8'h84;
  localparam logic [7:0] HDR_VER  = 8'h01;
  localparam logic [7:0] HDR_LEN  = 8'h0A;
  localparam logic [7:0] CA_FULL  = 8'h13;

  // Speaker-allocation rewrite: any nonzero code becomes the eight-channel code.
  function automatic logic [7:0] ca_fix(logic [7:0] v);
    return (v != 8'h00) ? CA_FULL : 8'h00;
  endfunction

  // Two's-complement checksum over header plus stored payload (reserved bytes are zero).
  function automatic logic [7:0] pkt_csum(logic [SW_N*8-1:0] sw);
    logic [7:0] s;
    s = HDR_TYPE + HDR_VER + HDR_LEN;
    for (int k = 0; k < SW_N; k++) s = s + sw[k*8 +: 8];
    return 8'h00 - s;
  endfunction

  // Byte at stream position i.
  function automatic logic [7:0] pick_byte(logic [IDX_W-1:0] i,
                                           logic [SW_N*8-1:0] sw,
                                           logic [7:0] cs);
    logic [7:0] b;
    b = 8'h00;
    if (i == IDX_W'(0)) b = HDR_TYPE;
    else if (i == IDX_W'(1)) b = HDR_VER;
    else if (i == IDX_W'(2)) b = HDR_LEN;
    else if (i == IDX_W'(3)) b = cs;
    else begin
      for (int k = 0; k < SW_N; k++)
        if (i == IDX_W'(HDR_N + 1 + k)) b = sw[k*8 +: 8];
    end
    return b;
  endfunction
endpackage

// File: rtl/aif_regbank.sv
module aif_regbank
  import aif_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              en_clr,
  output logic [SW_N*8-1:0] sw_bytes,
  output logic              ctrl_en,
  output logic              ctrl_rep
);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

  logic ctrl_hit;
  assign ctrl_hit = wr_en && (wr_addr == CTRL_A);

  for (genvar g = 0; g < SW_N; g++) begin : g_byte
    logic [7:0] q;
    logic       hit;
    logic [7:0] nxt;
    assign hit = wr_en && (wr_addr == ADDR_W'(g));
    if (g == CA_SLOT) begin : g_ca
      assign nxt = ca_fix(wr_data);
    end else begin : g_plain
      assign nxt = wr_data;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= 8'h00;
      else if (hit) q <= nxt;
    end
    assign sw_bytes[g*8 +: 8] = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_en  <= 1'b0;
      ctrl_rep <= 1'b0;
    end else if (ctrl_hit) begin
      ctrl_en  <= wr_data[EN_BIT];
      ctrl_rep <= wr_data[REP_BIT];
    end else if (en_clr) begin
      ctrl_en  <= 1'b0;
    end
  end
endmodule

// File: rtl/aif_checksum.sv
module aif_checksum
  import aif_pkg::*;
(
  input  logic [SW_N*8-1:0] sw_bytes,
  output logic [7:0]        csum
);
  assign csum = pkt_csum(sw_bytes);
endmodule

// File: rtl/aif_streamer.sv
module aif_streamer
  import aif_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_tick,
  input  logic              ctrl_en,
  input  logic              ctrl_rep,
  input  logic [SW_N*8-1:0] sw_bytes,
  input  logic [7:0]        csum,
  output logic              launch,
  output logic              en_clr,
  output logic              pkt_last,
  output logic              out_valid,
  output logic              out_first,
  output logic [7:0]        out_data
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PKT_N - 1);

  logic              busy;
  logic [IDX_W-1:0]  idx;
  logic [SW_N*8-1:0] snap_sw;
  logic [7:0]        snap_cs;

  assign launch   = frame_tick && ctrl_en && !busy;
  assign en_clr   = launch && !ctrl_rep;
  assign pkt_last = busy && (idx == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      idx     <= '0;
      snap_sw <= '0;
      snap_cs <= 8'h00;
    end else if (launch) begin
      busy    <= 1'b1;
      idx     <= '0;
      snap_sw <= sw_bytes;
      snap_cs <= csum;
    end else if (busy) begin
      if (pkt_last) busy <= 1'b0;
      else          idx  <= idx + IDX_W'(1);
    end
  end

  assign out_valid = busy;
  assign out_first = busy && (idx == '0);
  assign out_data  = busy ? pick_byte(idx, snap_sw, snap_cs) : 8'h00;
endmodule

// File: rtl/aif_pkt_builder.sv
module aif_pkt_builder
  import aif_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  input  logic              frame_tick,
  output logic              out_valid,
  output logic              out_first,
  output logic [7:0]        out_data
);
  logic [SW_N*8-1:0] sw_bytes;
  logic              ctrl_en, ctrl_rep;
  logic [7:0]        csum;
  logic              launch, en_clr, pkt_last;

  aif_regbank #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .en_clr(en_clr), .sw_bytes(sw_bytes), .ctrl_en(ctrl_en), .ctrl_rep(ctrl_rep)
  );

  aif_checksum u_csum (.sw_bytes(sw_bytes), .csum(csum));

  aif_streamer u_strm (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .ctrl_en(ctrl_en),
    .ctrl_rep(ctrl_rep), .sw_bytes(sw_bytes), .csum(csum), .launch(launch),
    .en_clr(en_clr), .pkt_last(pkt_last), .out_valid(out_valid),
    .out_first(out_first), .out_data(out_data)
  );

  always_comb begin
    rd_data = 8'h00;
    for (int k = 0; k < SW_N; k++)
      if (rd_addr == ADDR_W'(k)) rd_data = sw_bytes[k*8 +: 8];
    if (rd_addr == ADDR_W'(CTRL_ADDR)) begin
      rd_data[EN_BIT]  = ctrl_en;
      rd_data[REP_BIT] = ctrl_rep;
    end
    if (rd_addr == ADDR_W'(CSUM_ADDR)) rd_data = csum;
  end
endmodule

// File: rtl/aif_pkt_builder_chk.sv
module aif_pkt_builder_chk
  import aif_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              ctrl_en,
  input logic              ctrl_rep,
  input logic              launch,
  input logic              pkt_last,
  input logic              out_valid,
  input logic              out_first,
  input logic [7:0]        out_data
);
  logic [7:0] acc;
  logic [4:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= 8'h00;
      cnt <= 5'd0;
    end else if (out_first) begin
      acc <= out_data;
      cnt <= 5'd1;
    end else if (out_valid) begin
      acc <= acc + out_data;
      cnt <= cnt + 5'd1;
    end
  end

  a_r2_first_is_type: assert property (@(posedge clk) disable iff (!rst_n)
    out_first |-> (out_valid && out_data == HDR_TYPE));

  a_r2_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> (cnt == 5'(PKT_N)));

  a_r5_sum_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_last && !out_first) |-> (8'(acc + out_data) == 8'h00));

  a_r8_oneshot_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && !ctrl_rep && !(wr_en && wr_addr == ADDR_W'(CTRL_ADDR))) |=> !ctrl_en);

  a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !pkt_last) |=> (out_valid && !out_first));
endmodule

bind aif_pkt_builder aif_pkt_builder_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .ctrl_en(ctrl_en), .ctrl_rep(ctrl_rep), .launch(launch), .pkt_last(pkt_last),
  .out_valid(out_valid), .out_first(out_first), .out_data(out_data)
);

// File: tb/aif_pkt_builder_tb.sv
module aif_pkt_builder_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = 4'd0;
  logic [7:0] wr_data = 8'd0;
  logic [3:0] rd_addr = 4'd0;
  logic [7:0] rd_data;
  logic       frame_tick = 1'b0;
  logic       out_valid, out_first;
  logic [7:0] out_data;

  int checks = 0, fails = 0, cyc = 0, pkt_seen = 0;
  int m_db[5];
  bit m_en, m_rep, was_idle;
  int q[$];

  always #4 clk = ~clk;

  aif_pkt_builder u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .frame_tick(frame_tick),
    .out_valid(out_valid), .out_first(out_first), .out_data(out_data)
  );

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int ref_csum();
    int s = 'h84 + 'h01 + 'h0A;
    foreach (m_db[k]) s += m_db[k];
    return (256 - (s % 256)) % 256;
  endfunction

  function automatic int ref_read(int a);
    if (a < 5) return m_db[a];
    if (a == 8) return (int'(m_en) << 5) | (int'(m_rep) << 4);
    if (a == 9) return ref_csum();
    return 0;
  endfunction

  // behavioural reference model
  always @(posedge clk) begin
    rd_addr <= (rd_addr == 4'd9) ? 4'd0 : rd_addr + 4'd1;
    if (!rst_n) begin
      foreach (m_db[k]) m_db[k] = 0;
      m_en = 0; m_rep = 0; q.delete();
    end else begin
      was_idle = (q.size() == 0);
      if (!was_idle) void'(q.pop_front());
      if (frame_tick && m_en && was_idle) begin
        q.push_back('h84); q.push_back('h01); q.push_back('h0A);
        q.push_back(ref_csum());
        foreach (m_db[k]) q.push_back(m_db[k]);
        repeat (5) q.push_back(0);
        if (!m_rep) m_en = 0;
      end
      if (wr_en) begin
        if (wr_addr < 5) m_db[wr_addr] = (wr_addr == 3 && wr_data != 0) ? 'h13 : int'(wr_data);
        else if (wr_addr == 8) begin m_en = wr_data[5]; m_rep = wr_data[4]; end
      end
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      check(out_valid == (q.size() > 0), "R2 valid", out_valid, q.size() > 0);
      if (q.size() > 0) begin
        check(int'(out_data) == q[0], "R2 data", out_data, q[0]);
        check(out_first == (q.size() == 14), "R2 first", out_first, q.size() == 14);
      end
      if (rd_addr < 5)       check(int'(rd_data) == ref_read(rd_addr), "R4 read", rd_data, ref_read(rd_addr));
      else if (rd_addr == 8) check(int'(rd_data) == ref_read(8), "R6 ctrl", rd_data, ref_read(8));
      else if (rd_addr == 9) check(int'(rd_data) == ref_read(9), "R5 csum", rd_data, ref_read(9));
      else                   check(rd_data == 8'h00, "R3 reserved", rd_data, 0);
      if (out_first) pkt_seen++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic step(bit t, bit we, int a, int d);
    frame_tick = t; wr_en = we; wr_addr = 4'(a); wr_data = 8'(d);
    @(posedge clk); #1;
    frame_tick = 0; wr_en = 0;
  endtask

  task automatic idle(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(out_valid == 0, "R1 out_valid", out_valid, 0);
    @(posedge clk); #1;
    idle(10); // readback rotation covers checksum 0x71 (R1)
    step(0, 1, 0, 'h11); step(0, 1, 1, 'h22); step(0, 1, 2, 'h33);
    step(0, 1, 3, 'h05); step(0, 1, 4, 'h44);
    step(0, 1, 6, 'hFF); // R3 ignored
    step(1, 0, 0, 0);    // R6 tick while disabled
    idle(12);
    check(pkt_seen == 0, "R6 no packet when disabled", pkt_seen, 0);
    // R8 one-shot
    step(0, 1, 8, 'h20);
    step(1, 0, 0, 0);
    idle(20);
    step(1, 0, 0, 0);
    idle(20);
    check(pkt_seen == 1, "R8 one packet only", pkt_seen, 1);
    // R7 repeat with R9/R10 collisions
    step(0, 1, 8, 'h30);
    step(1, 1, 0, 'hA5);      // R10 write on launch edge
    idle(4);
    step(1, 1, 1, 'h5A);      // R9 tick mid-stream, R10 write mid-stream
    idle(8);                  // final-byte edge next
    step(1, 0, 0, 0);         // R9 tick on last-byte edge
    idle(2);
    check(pkt_seen == 2, "R9 mid-stream ticks ignored", pkt_seen, 2);
    step(1, 1, 3, 'h00);      // R4 zero allocation, R7 relaunch
    idle(15);
    step(1, 0, 0, 0);         // immediate relaunch when idle
    idle(16);
    check(pkt_seen == 4, "R7 every idle tick sends", pkt_seen, 4);
    // R8 control write on one-shot launch edge wins
    step(0, 1, 8, 'h20);
    step(1, 1, 8, 'h30);
    idle(16);
    step(1, 0, 0, 0);
    idle(16);
    check(pkt_seen == 6, "R8 write wins on launch edge", pkt_seen, 6);
    step(0, 1, 3, 'h80);      // R4 remap again
    step(0, 1, 8, 'h00);
    idle(12);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule